// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Sequencer

This block turns a PWM command into two gate enables for one synchronous buck half-bridge, a high-side enable and a low-side enable. It never lets both enables be high in the same cycle. A gate may turn on only after the opposite gate's comparator flag reports that gate below its turn-off threshold. A programmable extra dead-time then elapses before the turn-on. All timing is counted in clock cycles.

The block has two protection modes. When an external window comparator reports that the PWM input sits at its mid level for long enough, both gates are forced low and a shutdown status is raised. When forced-continuous mode is off, diode emulation ends each low-side pulse at the inductor zero crossing, but never before a minimum on-time has passed. The gate drivers, the comparators and the bootstrap supply are outside the block and connect to it as digital flags.

Top module: `hb_deadtime_seq`

## Requirements
- R1: `highOn` and `lowOn` are never high in the same cycle.
- R2: After `pwmIn` goes high, `lowOn` drops on the next clock edge. `highOn` stays low for as long as `lowBelowThr` is 0.
- R3: After `pwmIn` goes low, `highOn` drops on the next clock edge. `lowOn` stays low for as long as `highBelowThr` is 0.
- R4: On a PWM transition, the gate being turned on rises at the `MIN_DEAD + extraDelay`-th clock edge at which the watched feedback flag is sampled high. This holds for every `extraDelay` value from 0 to 2^`DLY_W`-1.
- R5: When `midLevel` is high for `HOLDOFF` consecutive edges, `shutdown` rises and both gates go low. A shorter excursion leaves the gates unchanged. While `midLevel` is high, `pwmIn` is ignored.
- R6: On the first edge at which `midLevel` is sampled low, `shutdown` clears. At that same edge, the gate selected by `pwmIn` turns on with no extra dead-time, provided the opposite gate's flag is set.
- R7: With `forcedCont` = 0, a high `zeroCross` turns `lowOn` off, but only after `lowOn` has been high for at least `MIN_LS_ON` cycles.
- R8: After a zero-cross turn-off, `lowOn` stays low until `pwmIn` rises. The rise then starts the normal high-side sequence, including its dead-time.
- R9: With `forcedCont` = 1, `zeroCross` has no effect. A change of `forcedCont` acts on the next clock edge, whatever the PWM phase.
- R10: `enable` = 0 forces both gates low on the next edge. From this idle state, raising `enable` turns on the gate selected by `pwmIn` on the next edge, with no dead-time, if the opposite flag is set.
- R11: During reset, `highOn`, `lowOn` and `shutdown` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel enable |
| pwmIn | input | 1 | PWM command level (1 = high side) |
| midLevel | input | 1 | Window comparator: PWM input is at its mid level |
| lowBelowThr | input | 1 | Low-side gate is below its turn-off threshold |
| highBelowThr | input | 1 | High-side gate-to-source voltage is below threshold |
| forcedCont | input | 1 | 1 = forced continuous, 0 = diode emulation |
| extraDelay | input | DLY_W | Extra dead-time in cycles |
| zeroCross | input | 1 | Inductor current has reached zero |
| highOn | output | 1 | High-side gate enable |
| lowOn | output | 1 | Low-side gate enable |
| shutdown | output | 1 | Mid-level shutdown active |

## Verification
The hardest situation to reach is the exact edge of the low-side minimum on-time under diode emulation. `zeroCross` is held high from before the low-side turn-on, so the bench must see the pulse end at precisely `MIN_LS_ON` cycles, neither earlier nor later. A second awkward case is a mid-level excursion that ends one edge short of the holdoff, while `pwmIn` changes during the excursion. The bench reaches both cases by holding the feedback flags steady and counting sampled cycles. Every extra dead-time value is swept, in both directions.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW_ON,
    ST_TO_HIGH,
    ST_HIGH_ON,
    ST_TO_LOW,
    ST_LOW_DONE,
    ST_SHUT
  } seqState_t;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic deadClr;
    logic deadRun;
    logic watchLow;
    logic lsClr;
  } timerCtl_t;
endpackage

// File: rtl/hb_seq_timers.sv
module hb_seq_timers
  import hb_seq_pkg::*;
#(
  parameter int DLY_W     = 3,
  parameter int MIN_DEAD  = 1,
  parameter int HOLDOFF   = 4,
  parameter int MIN_LS_ON = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             midLevel,
  input  logic             lowBelowThr,
  input  logic             highBelowThr,
  input  logic [DLY_W-1:0] extraDelay,
  input  timerCtl_t        ctl,
  output logic             deadDone,
  output logic             triExpired,
  output logic             lsMinMet
);
  localparam int DEAD_MAX = MIN_DEAD + (1 << DLY_W) - 1;
  localparam int DEAD_W   = $clog2(DEAD_MAX + 1);
  localparam int TRI_W    = $clog2(HOLDOFF + 1);
  localparam int LS_W     = $clog2(MIN_LS_ON + 1);

  logic [DEAD_W-1:0] deadCnt;
  logic [DEAD_W-1:0] deadTarget;
  logic [TRI_W-1:0]  triCnt;
  logic [LS_W-1:0]   lsCnt;
  logic              watched;

  assign watched    = ctl.watchLow ? lowBelowThr : highBelowThr;
  assign deadTarget = DEAD_W'(MIN_DEAD) + DEAD_W'(extraDelay);
  assign deadDone   = watched && (deadCnt >= deadTarget - DEAD_W'(1));
  assign triExpired = midLevel && (triCnt >= TRI_W'(HOLDOFF - 1));
  assign lsMinMet   = lsCnt >= LS_W'(MIN_LS_ON - 1);

  // dead-time counter: runs only while the watched flag holds
  always_ff @(posedge clk) begin
    if (!rstN || ctl.deadClr || !watched)
      deadCnt <= '0;
    else if (ctl.deadRun && deadCnt != DEAD_W'(DEAD_MAX))
      deadCnt <= deadCnt + DEAD_W'(1);
  end

  // mid-level holdoff counter
  always_ff @(posedge clk) begin
    if (!rstN || !enable || !midLevel)
      triCnt <= '0;
    else if (triCnt != TRI_W'(HOLDOFF))
      triCnt <= triCnt + TRI_W'(1);
  end

  // low-side on-time counter
  always_ff @(posedge clk) begin
    if (!rstN || ctl.lsClr)
      lsCnt <= '0;
    else if (lsCnt != LS_W'(MIN_LS_ON))
      lsCnt <= lsCnt + LS_W'(1);
  end

  a_r5_holdoff_saturates: assert property (@(posedge clk) disable iff (!rstN)
    triCnt <= TRI_W'(HOLDOFF));
  a_r7_ls_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    lsCnt <= LS_W'(MIN_LS_ON));
endmodule

// File: rtl/hb_seq_ctrl.sv
module hb_seq_ctrl
  import hb_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      pwmIn,
  input  logic      midLevel,
  input  logic      lowBelowThr,
  input  logic      highBelowThr,
  input  logic      forcedCont,
  input  logic      zeroCross,
  input  logic      deadDone,
  input  logic      triExpired,
  input  logic      lsMinMet,
  output timerCtl_t ctl,
  output logic      highOn,
  output logic      lowOn,
  output logic      shutdown
);
  seqState_t state, nextState;
  logic inTransit;

  always_comb begin
    nextState = state;
    if (!enable)
      nextState = ST_IDLE;
    else if (state != ST_SHUT && triExpired)
      nextState = ST_SHUT;
    else if (!midLevel) begin
      unique case (state)
        ST_IDLE, ST_SHUT: begin
          if (pwmIn && lowBelowThr)        nextState = ST_HIGH_ON;
          else if (!pwmIn && highBelowThr) nextState = ST_LOW_ON;
          else                             nextState = ST_IDLE;
        end
        ST_LOW_ON: begin
          if (pwmIn)                                       nextState = ST_TO_HIGH;
          else if (!forcedCont && zeroCross && lsMinMet)   nextState = ST_LOW_DONE;
        end
        ST_TO_HIGH: begin
          if (!pwmIn)        nextState = ST_TO_LOW;
          else if (deadDone) nextState = ST_HIGH_ON;
        end
        ST_HIGH_ON: if (!pwmIn) nextState = ST_TO_LOW;
        ST_TO_LOW: begin
          if (pwmIn)         nextState = ST_TO_HIGH;
          else if (deadDone) nextState = ST_LOW_ON;
        end
        ST_LOW_DONE: if (pwmIn) nextState = ST_TO_HIGH;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign inTransit    = (state == ST_TO_HIGH) || (state == ST_TO_LOW);
  assign ctl.watchLow = (state == ST_TO_HIGH);
  assign ctl.deadRun  = inTransit && !midLevel;
  assign ctl.deadClr  = !inTransit || (nextState != state);
  assign ctl.lsClr    = (state != ST_LOW_ON);

  assign highOn   = (state == ST_HIGH_ON);
  assign lowOn    = (state == ST_LOW_ON);
  assign shutdown = (state == ST_SHUT);

  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(highOn && lowOn));
  a_r2_high_after_flag: assert property (@(posedge clk) disable iff (!rstN)
    $rose(highOn) |-> $past(lowBelowThr));
  a_r3_low_after_flag: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lowOn) |-> $past(highBelowThr));
  a_r5_shut_needs_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shutdown) |-> $past(midLevel));
  a_r10_enable_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!highOn && !lowOn));
endmodule

// File: rtl/hb_deadtime_seq.sv
module hb_deadtime_seq
  import hb_seq_pkg::*;
#(
  parameter int DLY_W     = 3,
  parameter int MIN_DEAD  = 1,
  parameter int HOLDOFF   = 4,
  parameter int MIN_LS_ON = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             pwmIn,
  input  logic             midLevel,
  input  logic             lowBelowThr,
  input  logic             highBelowThr,
  input  logic             forcedCont,
  input  logic [DLY_W-1:0] extraDelay,
  input  logic             zeroCross,
  output logic             highOn,
  output logic             lowOn,
  output logic             shutdown
);
  timerCtl_t ctl;
  logic deadDone, triExpired, lsMinMet;

  hb_seq_timers #(
    .DLY_W(DLY_W), .MIN_DEAD(MIN_DEAD), .HOLDOFF(HOLDOFF), .MIN_LS_ON(MIN_LS_ON)
  ) uTimers (
    .clk(clk), .rstN(rstN), .enable(enable), .midLevel(midLevel),
    .lowBelowThr(lowBelowThr), .highBelowThr(highBelowThr),
    .extraDelay(extraDelay), .ctl(ctl),
    .deadDone(deadDone), .triExpired(triExpired), .lsMinMet(lsMinMet)
  );

  hb_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .pwmIn(pwmIn), .midLevel(midLevel),
    .lowBelowThr(lowBelowThr), .highBelowThr(highBelowThr),
    .forcedCont(forcedCont), .zeroCross(zeroCross),
    .deadDone(deadDone), .triExpired(triExpired), .lsMinMet(lsMinMet),
    .ctl(ctl), .highOn(highOn), .lowOn(lowOn), .shutdown(shutdown)
  );
endmodule

// File: tb/hb_deadtime_seq_test.sv
module hb_deadtime_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DLY_W      = 3;
  localparam int MIN_DEAD   = 1;
  localparam int HOLDOFF    = 4;
  localparam int MIN_LS_ON  = 8;

  logic clk = 1'b0;
  logic rstN, enable, pwmIn, midLevel, lowBelowThr, highBelowThr;
  logic forcedCont, zeroCross;
  logic [DLY_W-1:0] extraDelay;
  logic highOn, lowOn, shutdown;
  int checks = 0;
  int errors = 0;
  int overlaps = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_deadtime_seq #(
    .DLY_W(DLY_W), .MIN_DEAD(MIN_DEAD), .HOLDOFF(HOLDOFF), .MIN_LS_ON(MIN_LS_ON)
  ) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .pwmIn(pwmIn), .midLevel(midLevel),
    .lowBelowThr(lowBelowThr), .highBelowThr(highBelowThr),
    .forcedCont(forcedCont), .extraDelay(extraDelay), .zeroCross(zeroCross),
    .highOn(highOn), .lowOn(lowOn), .shutdown(shutdown)
  );

  always @(negedge clk) if (rstN && highOn && lowOn) overlaps++;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // steps until the chosen gate is on; n = sample index where it appears
  task automatic waitGate(input bit wantHigh, output int n);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      step();
      n++;
      if (wantHigh ? highOn : lowOn) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    int cnt;
    rstN = 0; enable = 1; pwmIn = 0; midLevel = 0; lowBelowThr = 1; highBelowThr = 1;
    forcedCont = 1; zeroCross = 0; extraDelay = '0;
    repeat (3) step();
    check(!highOn && !lowOn && !shutdown, "R11 reset outputs", {highOn, lowOn, shutdown}, 0);
    rstN = 1;
    waitGate(1'b0, n);
    check(n == 1, "R10 start from idle without dead-time", n, 1);

    // R4 sweep of every extra delay in both directions
    for (int e = 0; e < (1 << DLY_W); e++) begin
      extraDelay = DLY_W'(e);
      pwmIn = 1;
      waitGate(1'b1, n);
      check(n == MIN_DEAD + e + 1, "R4 rise dead-time", n, MIN_DEAD + e + 1);
      pwmIn = 0;
      waitGate(1'b0, n);
      check(n == MIN_DEAD + e + 1, "R4 fall dead-time", n, MIN_DEAD + e + 1);
    end

    // R2 high side waits for the low-side flag
    extraDelay = 2;
    lowBelowThr = 0;
    pwmIn = 1;
    step();
    check(!lowOn, "R2 low gate dropped", lowOn, 0);
    repeat (19) step();
    check(!highOn, "R2 high held without flag", highOn, 0);
    lowBelowThr = 1;
    waitGate(1'b1, n);
    check(n == MIN_DEAD + 2, "R2 count from flag", n, MIN_DEAD + 2);

    // R3 low side waits for the high-side flag
    highBelowThr = 0;
    pwmIn = 0;
    step();
    check(!highOn, "R3 high gate dropped", highOn, 0);
    repeat (19) step();
    check(!lowOn, "R3 low held without flag", lowOn, 0);
    highBelowThr = 1;
    waitGate(1'b0, n);
    check(n == MIN_DEAD + 2, "R3 count from flag", n, MIN_DEAD + 2);

    // R5 / R6 mid-level excursions of every length up to the holdoff
    extraDelay = '1;
    pwmIn = 1;
    waitGate(1'b1, n);
    for (int h = 1; h <= HOLDOFF + 1; h++) begin
      midLevel = 1;
      pwmIn = 0;
      repeat (h) step();
      check(shutdown == (h >= HOLDOFF), "R5 shutdown after holdoff", shutdown, h >= HOLDOFF);
      check(highOn == (h < HOLDOFF), "R5 gate state during window", highOn, h < HOLDOFF);
      check(!lowOn, "R5 pwm ignored in window", lowOn, 0);
      midLevel = 0;
      pwmIn = 1;
      step();
      check(!shutdown && highOn, "R6 fast exit from window", {shutdown, highOn}, 1);
    end

    // R7 / R8 diode emulation with zero crossing already present
    forcedCont = 0;
    zeroCross = 1;
    extraDelay = 1;
    pwmIn = 0;
    waitGate(1'b0, n);
    check(n == MIN_DEAD + 2, "R7 low turn-on", n, MIN_DEAD + 2);
    cnt = 1;
    for (int i = 0; i < 100 && lowOn; i++) begin
      step();
      if (lowOn) cnt++;
    end
    check(cnt == MIN_LS_ON, "R7 minimum low on-time", cnt, MIN_LS_ON);
    zeroCross = 0;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (lowOn || highOn) cnt++;
    end
    check(cnt == 0, "R8 low stays off after zero cross", cnt, 0);
    pwmIn = 1;
    waitGate(1'b1, n);
    check(n == MIN_DEAD + 2, "R8 next rise uses dead-time", n, MIN_DEAD + 2);

    // R7 late zero crossing
    pwmIn = 0;
    waitGate(1'b0, n);
    repeat (20) step();
    check(lowOn, "R7 low held without zero cross", lowOn, 1);
    zeroCross = 1;
    step();
    check(!lowOn, "R7 late zero cross turns off", lowOn, 0);

    // R9 forced continuous ignores zero cross; mode change is immediate
    forcedCont = 1;
    pwmIn = 1;
    waitGate(1'b1, n);
    pwmIn = 0;
    waitGate(1'b0, n);
    repeat (30) step();
    check(lowOn, "R9 zero cross ignored", lowOn, 1);
    forcedCont = 0;
    step();
    check(!lowOn, "R9 mode change immediate", lowOn, 0);

    // R10 enable
    forcedCont = 1;
    zeroCross = 0;
    pwmIn = 1;
    waitGate(1'b1, n);
    enable = 0;
    step();
    check(!highOn && !lowOn && !shutdown, "R10 disable drops gates", {highOn, lowOn}, 0);
    pwmIn = 0;
    repeat (5) step();
    check(!lowOn, "R10 held low while disabled", lowOn, 0);
    enable = 1;
    step();
    check(lowOn, "R10 re-enable fast start", lowOn, 1);

    check(overlaps == 0, "R1 gate overlap count", overlaps, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule